// File: doc/BRIEF.md
# Split-Field Memory Bank Select Register

This block sits on the host's I/O write path and picks one of 64 banks of 64 KB in an expansion memory. It watches every I/O write. A write counts only when the upper five address bits carry the fixed port pattern and the top two data bits are both set. When a write counts, the block stores a 6-bit bank number and a 3-bit configuration code. Three bits of the bank number come from the address bus and three from the data bus of that same write. Because of this split, a single write instruction carries a complete bank choice, and the whole group of eight port addresses 0x78xx to 0x7Fxx is accepted.

The low address byte plays no part in decoding. Software can set it to any value that keeps other peripherals from answering the same write. The stored values stay the same until the next qualifying write or until reset. The memory controller downstream reads the bank number, the configuration code and a flag. The flag says whether any expansion RAM is mapped in. Reset is asynchronous on assertion. Its release is synchronised to the clock inside the block.

Top module: `xbank_select`

## Requirements
- R1: While reset is held, and until the first qualifying write after reset, `bank_sel` is 0, `cfg_mode` is 0 and `xmem_mapped` is 0.
- R2: A write is taken only when `io_addr[15:11]` equals 5'b01111. With any other value in those bits, the outputs keep their previous values.
- R3: All eight ports 0x78xx to 0x7Fxx are accepted, and `io_addr[10:8]` becomes `bank_sel[5:3]`.
- R4: `io_data[5:3]` of a taken write becomes `bank_sel[2:0]`.
- R5: `io_data[2:0]` of a taken write becomes `cfg_mode`.
- R6: A write is taken only when `io_data[7:6]` is 2'b11. The values 00, 01 and 10 leave the outputs unchanged.
- R7: `io_addr[7:0]` has no effect. Writes that differ only in those bits produce identical outputs.
- R8: After a taken write, `xmem_mapped` is 1 exactly when the stored configuration code is not 0.
- R9: While `io_wr` is low, the outputs hold, whatever the address and data buses carry.
- R10: A taken write is sampled on a rising clock edge. The new values appear right after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 16 | Host I/O address |
| io_data | input | 8 | Host I/O write data |
| io_wr | input | 1 | I/O write strobe, active high, sampled on each rising edge |
| bank_sel | output | 6 | Stored bank number, {address bits 10..8, data bits 5..3} |
| cfg_mode | output | 3 | Stored configuration code |
| xmem_mapped | output | 1 | High when the stored configuration maps expansion RAM in |

## Verification
The address qualification and the data qualification are judged in the same cycle, and a write must pass both to be taken. The random stimulus therefore mixes four kinds of write: port hit with good data tag, port hit with bad tag, port miss with good tag, and port miss with bad tag. After each edge, the bench compares the outputs with a model that applies both tests together. Directed cases put a bad tag on each of the eight accepted ports. They also put a good tag on the addresses just outside the accepted group. This makes sure neither test alone can let a write through.

// File: rtl/xbank_pkg.sv
package xbank_pkg;

  // Outcome of decoding one bus cycle
  typedef enum logic [1:0] {
    DEC_IDLE     = 2'd0,
    DEC_TAKE     = 2'd1,
    DEC_BAD_PORT = 2'd2,
    DEC_BAD_TAG  = 2'd3
  } dec_res_e;

  localparam int unsigned DEF_ADDR_W  = 16;
  localparam int unsigned DEF_DATA_W  = 8;
  localparam int unsigned DEF_MATCH_W = 5;
  localparam int unsigned DEF_HI_W    = 3;
  localparam int unsigned DEF_LO_W    = 3;
  localparam int unsigned DEF_CFG_W   = 3;
  localparam int unsigned DEF_TAG_W   = 2;

endpackage

// File: rtl/xbank_rst_sync.sv
module xbank_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/xbank_port_match.sv
module xbank_port_match #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned MATCH_W = 5,
  parameter int unsigned HI_W    = 3,
  parameter logic [MATCH_W-1:0] PATTERN = 5'b01111
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [HI_W-1:0]   hi_bits
);

  localparam int unsigned MATCH_LSB = ADDR_W - MATCH_W;
  localparam int unsigned HI_LSB    = MATCH_LSB - HI_W;
  localparam int unsigned FREE_W    = HI_LSB;

  logic [MATCH_W-1:0] match_field;
  logic               unused_free_bits;

  always_comb begin
    match_field = addr[ADDR_W-1:MATCH_LSB];
    hit         = (match_field == PATTERN);
    hi_bits     = addr[MATCH_LSB-1:HI_LSB];
  end

  // Low address byte is left free for software; fold it so it is consumed
  generate
    if (FREE_W > 0) begin : g_free
      assign unused_free_bits = ^addr[FREE_W-1:0];
    end else begin : g_nofree
      assign unused_free_bits = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/xbank_data_split.sv
module xbank_data_split #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TAG_W  = 2,
  parameter int unsigned LO_W   = 3,
  parameter int unsigned CFG_W  = 3
) (
  input  logic [DATA_W-1:0] data,
  output logic              tag_ok,
  output logic [LO_W-1:0]   lo_bits,
  output logic [CFG_W-1:0]  cfg
);

  localparam int unsigned TAG_LSB = DATA_W - TAG_W;
  localparam int unsigned LO_LSB  = CFG_W;

  always_comb begin
    tag_ok  = &data[DATA_W-1:TAG_LSB];
    lo_bits = data[LO_LSB+LO_W-1:LO_LSB];
    cfg     = data[CFG_W-1:0];
  end

endmodule

// File: rtl/xbank_regs.sv
module xbank_regs #(
  parameter int unsigned BANK_W = 6,
  parameter int unsigned CFG_W  = 3
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              load_en,
  input  logic [BANK_W-1:0] bank_d,
  input  logic [CFG_W-1:0]  cfg_d,
  output logic [BANK_W-1:0] bank_q,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              mapped_q
);

  logic [BANK_W-1:0] bank_nx;
  logic [CFG_W-1:0]  cfg_nx;
  logic              mapped_nx;

  // Next-state: explicit clock enable, hold otherwise
  always_comb begin
    bank_nx   = bank_q;
    cfg_nx    = cfg_q;
    mapped_nx = mapped_q;
    if (load_en) begin
      bank_nx   = bank_d;
      cfg_nx    = cfg_d;
      mapped_nx = |cfg_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      bank_q   <= '0;
      cfg_q    <= '0;
      mapped_q <= 1'b0;
    end else begin
      bank_q   <= bank_nx;
      cfg_q    <= cfg_nx;
      mapped_q <= mapped_nx;
    end
  end

endmodule

// File: rtl/xbank_select.sv
module xbank_select
  import xbank_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned MATCH_W = DEF_MATCH_W,
  parameter int unsigned HI_W    = DEF_HI_W,
  parameter int unsigned LO_W    = DEF_LO_W,
  parameter int unsigned CFG_W   = DEF_CFG_W,
  parameter int unsigned TAG_W   = DEF_TAG_W,
  parameter logic [MATCH_W-1:0] PORT_PATTERN = 5'b01111,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      io_addr,
  input  logic [DATA_W-1:0]      io_data,
  input  logic                   io_wr,
  output logic [HI_W+LO_W-1:0]   bank_sel,
  output logic [CFG_W-1:0]       cfg_mode,
  output logic                   xmem_mapped
);

  localparam int unsigned BANK_W = HI_W + LO_W;

  logic              srst_n;
  logic              port_hit;
  logic              tag_ok;
  logic [HI_W-1:0]   bank_hi;
  logic [LO_W-1:0]   bank_lo;
  logic [CFG_W-1:0]  cfg_new;
  logic [BANK_W-1:0] bank_new;
  logic              load_en;
  dec_res_e          dec_res;

  xbank_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  xbank_port_match #(
    .ADDR_W  (ADDR_W),
    .MATCH_W (MATCH_W),
    .HI_W    (HI_W),
    .PATTERN (PORT_PATTERN)
  ) i_port_match (
    .addr    (io_addr),
    .hit     (port_hit),
    .hi_bits (bank_hi)
  );

  xbank_data_split #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .LO_W   (LO_W),
    .CFG_W  (CFG_W)
  ) i_data_split (
    .data    (io_data),
    .tag_ok  (tag_ok),
    .lo_bits (bank_lo),
    .cfg     (cfg_new)
  );

  // Both qualifications must pass in the same cycle
  always_comb begin
    if (!io_wr) begin
      dec_res = DEC_IDLE;
    end else if (!port_hit) begin
      dec_res = DEC_BAD_PORT;
    end else if (!tag_ok) begin
      dec_res = DEC_BAD_TAG;
    end else begin
      dec_res = DEC_TAKE;
    end
    load_en  = (dec_res == DEC_TAKE);
    bank_new = {bank_hi, bank_lo};
  end

  xbank_regs #(
    .BANK_W (BANK_W),
    .CFG_W  (CFG_W)
  ) i_regs (
    .clk      (clk),
    .srst_n   (srst_n),
    .load_en  (load_en),
    .bank_d   (bank_new),
    .cfg_d    (cfg_new),
    .bank_q   (bank_sel),
    .cfg_q    (cfg_mode),
    .mapped_q (xmem_mapped)
  );

endmodule

// File: rtl/xbank_select_chk.sv
module xbank_select_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MATCH_W = 5,
  parameter int unsigned HI_W    = 3,
  parameter int unsigned LO_W    = 3,
  parameter int unsigned CFG_W   = 3,
  parameter int unsigned TAG_W   = 2,
  parameter logic [MATCH_W-1:0] PORT_PATTERN = 5'b01111
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 srst_n,
  input logic [ADDR_W-1:0]    io_addr,
  input logic [DATA_W-1:0]    io_data,
  input logic                 io_wr,
  input logic [HI_W+LO_W-1:0] bank_sel,
  input logic [CFG_W-1:0]     cfg_mode,
  input logic                 xmem_mapped
);

  localparam int unsigned MLSB = ADDR_W - MATCH_W;

  logic port_ok;
  logic tag_ok;
  logic take;

  assign port_ok = (io_addr[ADDR_W-1:MLSB] == PORT_PATTERN);
  assign tag_ok  = (io_data[DATA_W-1:DATA_W-TAG_W] == {TAG_W{1'b1}});
  assign take    = io_wr && port_ok && tag_ok;

  always_comb begin
    if (!rst_n) begin
      a_reset_clear_r1: assert (bank_sel == '0 && cfg_mode == '0 && !xmem_mapped);
    end
  end

  p_port_reject_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (io_wr && !port_ok) |=> ($stable(bank_sel) && $stable(cfg_mode)));

  p_load_hi_r3: assert property (@(posedge clk) disable iff (!srst_n)
    take |=> (bank_sel[HI_W+LO_W-1:LO_W] == $past(io_addr[MLSB-1:MLSB-HI_W])));

  p_load_lo_r4: assert property (@(posedge clk) disable iff (!srst_n)
    take |=> (bank_sel[LO_W-1:0] == $past(io_data[CFG_W+LO_W-1:CFG_W])));

  p_load_cfg_r5: assert property (@(posedge clk) disable iff (!srst_n)
    take |=> (cfg_mode == $past(io_data[CFG_W-1:0])));

  p_tag_reject_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (io_wr && port_ok && !tag_ok) |=> ($stable(bank_sel) && $stable(cfg_mode)));

  p_flag_match_r8: assert property (@(posedge clk) disable iff (!srst_n)
    take |=> (xmem_mapped == ($past(io_data[CFG_W-1:0]) != '0)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !io_wr |=> ($stable(bank_sel) && $stable(cfg_mode) && $stable(xmem_mapped)));

endmodule

bind xbank_select xbank_select_chk #(
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .MATCH_W      (MATCH_W),
  .HI_W         (HI_W),
  .LO_W         (LO_W),
  .CFG_W        (CFG_W),
  .TAG_W        (TAG_W),
  .PORT_PATTERN (PORT_PATTERN)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .srst_n      (srst_n),
  .io_addr     (io_addr),
  .io_data     (io_data),
  .io_wr       (io_wr),
  .bank_sel    (bank_sel),
  .cfg_mode    (cfg_mode),
  .xmem_mapped (xmem_mapped)
);

// File: tb/test_xbank_select.sv
`timescale 1ns/1ps
module test_xbank_select;

  logic        clk;
  logic        rst_n;
  logic [15:0] io_addr;
  logic [7:0]  io_data;
  logic        io_wr;
  logic [5:0]  bank_sel;
  logic [2:0]  cfg_mode;
  logic        xmem_mapped;

  int checks;
  int errors;
  bit done;

  logic [5:0] exp_bank;
  logic [2:0] exp_cfg;

  xbank_select i_xbank_select (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_data     (io_data),
    .io_wr       (io_wr),
    .bank_sel    (bank_sel),
    .cfg_mode    (cfg_mode),
    .xmem_mapped (xmem_mapped)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit qualifies(input logic [15:0] a, input logic [7:0] d);
    return (a[15:11] == 5'b01111) && (d[7:6] == 2'b11);
  endfunction

  function automatic logic [5:0] bank_of(input logic [15:0] a, input logic [7:0] d);
    return {a[10:8], d[5:3]};
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, bank_sel, exp_bank);
    check(tag, cfg_mode, exp_cfg);
    check({tag, "/R8"}, xmem_mapped, (exp_cfg != 0));
  endtask

  // Drive at negedge, let one rising edge pass, sample at next negedge
  task automatic step(input logic [15:0] a, input logic [7:0] d, input logic w, input string tag);
    io_addr = a;
    io_data = d;
    io_wr   = w;
    @(posedge clk);
    if (w && qualifies(a, d)) begin
      exp_bank = bank_of(a, d);
      exp_cfg  = d[2:0];
    end
    @(negedge clk);
    io_wr = 1'b0;
    check_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    logic [7:0]  d;
    int unsigned seed_dummy;
    checks = 0;
    errors = 0;
    done = 0;
    seed_dummy = $urandom(32'h5eed_0042);
    exp_bank = '0;
    exp_cfg  = '0;
    rst_n   = 1'b0;
    io_addr = 16'h7F00;
    io_data = 8'hFF;
    io_wr   = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");
    io_wr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R3: each of the eight ports, address bits 10..8 land in bank[5:3]
    for (int p = 0; p < 8; p++) begin
      step({5'b01111, p[2:0], 8'h00}, {2'b11, 3'd5, 3'd2}, 1'b1, "R3");
    end

    // R4 and R5: sweep data fields on one port
    for (int v = 0; v < 8; v++) begin
      step(16'h7A55, {2'b11, v[2:0], 3'(7 - v)}, 1'b1, "R4_R5");
    end

    // R8: configuration 0 clears the mapped flag
    step(16'h7C00, 8'b11_011_001, 1'b1, "R8");
    step(16'h7C00, 8'b11_011_000, 1'b1, "R8");
    check("R8", xmem_mapped, 0);

    // R6: bad tag on every accepted port
    step(16'h7B00, 8'b11_110_111, 1'b1, "R6");
    for (int p = 0; p < 8; p++) begin
      step({5'b01111, p[2:0], 8'h12}, 8'b10_000_001, 1'b1, "R6");
      step({5'b01111, p[2:0], 8'h34}, 8'b01_001_010, 1'b1, "R6");
      step({5'b01111, p[2:0], 8'h56}, 8'b00_010_011, 1'b1, "R6");
    end

    // R2: good tag just outside the group
    step(16'h77FF, 8'b11_000_100, 1'b1, "R2");
    step(16'h8000, 8'b11_000_100, 1'b1, "R2");
    step(16'hFF00, 8'b11_000_100, 1'b1, "R2");
    step(16'h3F00, 8'b11_000_100, 1'b1, "R2");

    // R7: low address byte has no effect
    step(16'h7D00, 8'b11_101_110, 1'b1, "R7");
    step(16'h7DFF, 8'b11_101_110, 1'b1, "R7");
    check("R7", bank_sel, 6'b101_101);

    // R9: strobe low with qualifying buses
    step(16'h7E00, 8'b11_001_001, 1'b0, "R9");
    check("R9", bank_sel, 6'b101_101);

    // R10: not visible before the edge, visible right after
    io_addr = 16'h7900;
    io_data = 8'b11_111_011;
    io_wr   = 1'b1;
    #1;
    check("R10", bank_sel, 6'b101_101);
    @(posedge clk);
    #1;
    io_wr = 1'b0;
    exp_bank = 6'b001_111;
    exp_cfg  = 3'd3;
    check("R10", bank_sel, 6'b001_111);
    check("R10", cfg_mode, 3);
    @(negedge clk);

    // Random mix of port hit/miss and tag good/bad
    for (int i = 0; i < 3000; i++) begin
      a = 16'($urandom);
      d = 8'($urandom);
      if ($urandom % 2 == 0) a[15:11] = 5'b01111;
      if ($urandom % 2 == 0) d[7:6]   = 2'b11;
      step(a, d, 1'($urandom % 4 != 0), "R2_R6_rand");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule